// File: doc/BRIEF.md
# Glitch-free multi-output clock enable controller

This block takes one reference clock and hands out gated copies of it on a set of clock outputs, twelve by default, plus one feedback output. Each gated output has two controls. One is an active-high enable bit from a parallel configuration vector. The other is an active-low hardware pin. An output runs only while its bit is set and its pin is pulled low.

A power-good input overrides everything. While it is low, every gated output and the feedback output are held low. The feedback output ignores the per-output controls and runs whenever power is good.

The controls may change at any moment, with no timing relation to the reference clock. Each output's combined request is resynchronized on the falling edge of the reference clock. A small per-output sequencer then decides the start and stop cycle. The gate opens and closes only while the clock is low, so every emitted pulse is a full half period wide. Once an output starts, it always delivers a minimum number of pulses before it stops.

Top module: `clk_enable_ctrl`

## Requirements
- R1: Gated output i toggles only while `pwr_good`=1, `sw_en[i]`=1 and `oe_n[i]`=0. Every other combination of those three inputs leaves that output not toggling.
- R2: An output that is not toggling rests at logic low, and never stops while high.
- R3: While `pwr_good` stays high, every high pulse on a gated output lasts exactly one half period of `clk_ref`. Every low gap between pulses lasts at least one half period. This holds whatever the timing of the enable changes.
- R4: After an output's enable condition becomes true, its first rising edge comes no sooner than 4 and no later than 12 `clk_ref` periods later.
- R5: After an output's enable condition becomes false, it emits at least 4 further rising edges. Its last falling edge comes no later than 12 `clk_ref` periods after the change.
- R6: While `pwr_good` is low, all gated outputs and `clk_fb` are low. A falling `pwr_good` forces them low at once, without waiting for a clock edge.
- R7: `clk_fb` runs whenever `pwr_good` is high, whatever the values of `oe_n` and `sw_en`. It starts within 4 periods of `pwr_good` rising.
- R8: A request that drops again before its output has started produces no pulse at all. Any burst of consecutive pulses on a gated output contains at least 4 pulses, unless power-good cuts it short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that all outputs copy |
| pwr_good | input | 1 | Active-high power good; low clears all state and silences every output |
| oe_n | input | NOUT | Asynchronous active-low hardware enable, one per gated output |
| sw_en | input | NOUT | Active-high configuration enable, one per gated output |
| clk_out | output | NOUT | Gated clock outputs |
| clk_fb | output | 1 | Feedback clock, gated only by power good |

## Verification
The embedded assertions watch the falling-edge sequencers on every cycle:
- a gate opens only after a synchronized request;
- once open, a gate stays open for at least four cycles;
- a gate is closed after a sufficiently long run of low requests;
- while power is not good, everything is quiet.

Other properties can only be shown by the bench's scenarios, because they are measured in absolute time from an asynchronous pin change. These are the start and stop latency windows, the count of trailing pulses, the exact width of every high pulse, and the truth table seen at the pins.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Per-output sequencer states
  typedef enum logic [1:0] {
    CH_OFF   = 2'd0,  // gate closed, waiting for a request
    CH_WARM  = 2'd1,  // request seen, counting down before opening
    CH_RUN   = 2'd2,  // gate open, request still present
    CH_DRAIN = 2'd3   // request gone, emitting the trailing cycles
  } ch_state_e;

  // Gate is open in the running and draining states
  function automatic logic gate_open(input ch_state_e s);
    return (s == CH_RUN) || (s == CH_DRAIN);
  endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Falling-edge flop chain; asynchronous clear, synchronous release
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cg_channel.sv
module cg_channel
  import clkgate_pkg::*;
#(
  parameter int START_WAIT  = 2,  // falling edges in WARM before opening (>= 1)
  parameter int STOP_CYCLES = 3   // falling edges in DRAIN before closing (>= 3)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,      // synchronized enable request
  output logic gate_en,
  output logic clk_gated
);

  localparam int CNT_MAX = (START_WAIT > STOP_CYCLES) ? START_WAIT : STOP_CYCLES;
  localparam int CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  ch_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CH_OFF: begin
        if (req_s) begin
          state_d = CH_WARM;
          cnt_d   = CW'(START_WAIT - 1);
        end
      end
      CH_WARM: begin
        if (!req_s) begin
          state_d = CH_OFF;
        end else if (cnt_q == '0) begin
          state_d = CH_RUN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      CH_RUN: begin
        if (!req_s) begin
          state_d = CH_DRAIN;
          cnt_d   = CW'(STOP_CYCLES - 1);
        end
      end
      CH_DRAIN: begin
        if (req_s) begin
          state_d = CH_RUN;
        end else if (cnt_q == '0) begin
          state_d = CH_OFF;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = CH_OFF;
    endcase
  end

  // State moves only on the falling edge, so the gate changes while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_en   = gate_open(state_q);
  assign clk_gated = clk & gate_en;

  // ---------------- assertions ----------------
  // Length of the current run of low request samples, saturating
  logic [3:0] low_run;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (req_s)       low_run <= '0;
    else if (low_run != 4'hF) low_run <= low_run + 1'b1;
  end

  // R1: the gate opens only right after a synchronized request was present
  a_r1_open_needs_req: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(req_s));

  // R8: once opened, the gate stays open for at least four cycles
  a_r8_min_burst: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(gate_en) |-> ($past(gate_en, 2) && $past(gate_en, 3) && $past(gate_en, 4)));

  // R5: a long enough run of low requests leaves the gate closed
  a_r5_closed_after_drain: assert property (@(negedge clk) disable iff (!rst_n)
    (int'(low_run) >= STOP_CYCLES + 1) |-> !gate_en);

endmodule

// File: rtl/clk_enable_ctrl.sv
module clk_enable_ctrl #(
  parameter int NOUT        = 12,
  parameter int SYNC_STAGES = 2,
  parameter int START_WAIT  = 2,
  parameter int STOP_CYCLES = 3
) (
  input  logic            clk_ref,
  input  logic            pwr_good,
  input  logic [NOUT-1:0] oe_n,
  input  logic [NOUT-1:0] sw_en,
  output logic [NOUT-1:0] clk_out,
  output logic            clk_fb
);

  // Power good: asynchronous assertion of the clear, falling-edge release
  logic pg_ok;
  cg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pg_sync (
    .clk   (clk_ref),
    .rst_n (pwr_good),
    .d     (1'b1),
    .q     (pg_ok)
  );

  // Both enables combined before synchronization: one crossing per output
  logic [NOUT-1:0] req_raw, req_s;
  assign req_raw = sw_en & ~oe_n;

  cg_sync #(.WIDTH(NOUT), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk_ref),
    .rst_n (pg_ok),
    .d     (req_raw),
    .q     (req_s)
  );

  logic [NOUT-1:0] gate_vec;

  for (genvar g = 0; g < NOUT; g++) begin : g_ch
    cg_channel #(
      .START_WAIT  (START_WAIT),
      .STOP_CYCLES (STOP_CYCLES)
    ) u_ch (
      .clk       (clk_ref),
      .rst_n     (pg_ok),
      .req_s     (req_s[g]),
      .gate_en   (gate_vec[g]),
      .clk_gated (clk_out[g])
    );
  end

  // Feedback gate: opens on the first falling edge after power is good
  logic fb_en;
  always_ff @(negedge clk_ref or negedge pg_ok) begin
    if (!pg_ok) fb_en <= 1'b0;
    else        fb_en <= 1'b1;
  end

  assign clk_fb = clk_ref & fb_en;

  // R6: while power is not good, no gate is open (antecedent is the clear itself)
  a_r6_powerdown_quiet: assert property (@(posedge clk_ref)
    !pwr_good |-> (!fb_en && (gate_vec == '0)));

endmodule

// File: tb/clk_enable_ctrl_tb_top.sv
module clk_enable_ctrl_tb_top;

  localparam int NOUT = 12;
  localparam int HALF = 10;   // 50 MHz
  localparam int PER  = 20;

  logic            clk_ref = 1'b0;
  logic            pwr_good = 1'b1;
  logic [NOUT-1:0] oe_n  = '1;
  logic [NOUT-1:0] sw_en = '1;
  logic [NOUT-1:0] clk_out;
  logic            clk_fb;

  always #HALF clk_ref = ~clk_ref;

  clk_enable_ctrl #(.NOUT(NOUT)) dut_i (
    .clk_ref  (clk_ref),
    .pwr_good (pwr_good),
    .oe_n     (oe_n),
    .sw_en    (sw_en),
    .clk_out  (clk_out),
    .clk_fb   (clk_fb)
  );

  // ---------------- monitor: edges, pulse widths, bursts ----------------
  int              rise_cnt [NOUT];
  time             last_rise [NOUT];
  time             last_fall [NOUT];
  int              burst [NOUT];
  int              fb_rise = 0;
  time             pg_drop_t = 0;
  logic [NOUT-1:0] prev_o = '0;
  logic            prev_pg = 1'b1;
  logic            prev_fb = 1'b0;
  int              mon_checks = 0;
  int              mon_errs = 0;

  initial begin
    for (int i = 0; i < NOUT; i++) begin
      rise_cnt[i] = 0; last_rise[i] = 0; last_fall[i] = 0; burst[i] = 0;
    end
  end

  always @(clk_out or pwr_good or clk_fb) begin
    if (prev_pg && !pwr_good) begin
      pg_drop_t = $time;
      for (int i = 0; i < NOUT; i++) burst[i] = 0;
    end
    if (clk_fb && !prev_fb) fb_rise++;
    for (int i = 0; i < NOUT; i++) begin
      if (clk_out[i] && !prev_o[i]) begin
        if (last_fall[i] > pg_drop_t) begin
          mon_checks++;
          if ($time - last_fall[i] < HALF) begin
            mon_errs++;
            $display("FAIL R3 out%0d low gap actual %0d expected >= %0d",
                     i, int'($time - last_fall[i]), HALF);
          end
        end
        if (burst[i] > 0 && ($time - last_rise[i]) == PER) begin
          burst[i]++;
        end else begin
          if (burst[i] > 0) begin
            mon_checks++;
            if (burst[i] < 4) begin
              mon_errs++;
              $display("FAIL R8 out%0d burst length actual %0d expected >= 4", i, burst[i]);
            end
          end
          burst[i] = 1;
        end
        last_rise[i] = $time;
        rise_cnt[i]++;
      end else if (!clk_out[i] && prev_o[i]) begin
        if (last_rise[i] > pg_drop_t) begin
          mon_checks++;
          if ($time - last_rise[i] != HALF) begin
            mon_errs++;
            $display("FAIL R3 out%0d high width actual %0d expected %0d",
                     i, int'($time - last_rise[i]), HALF);
          end
        end
        last_fall[i] = $time;
      end
    end
    prev_o  = clk_out;
    prev_pg = pwr_good;
    prev_fb = clk_fb;
  end

  // ---------------- checking helpers ----------------
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_run(input bit sw, input bit oen, input bit pg);
    return pg & sw & ~oen;
  endfunction

  // Move to a random point away from either clock edge
  task automatic drive_point();
    int off;
    @(posedge clk_ref);
    off = 1 + int'($urandom_range(0, 8)) + (($urandom_range(0, 1) == 1) ? HALF : 0);
    #(off);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_ref);
  endtask

  // Observe three periods and compare every output with the truth table
  task automatic check_state();
    int c0 [NOUT];
    int f0;
    @(posedge clk_ref); #5;
    for (int i = 0; i < NOUT; i++) c0[i] = rise_cnt[i];
    f0 = fb_rise;
    repeat (3) @(posedge clk_ref);
    #5;
    for (int i = 0; i < NOUT; i++) begin
      bit run;
      bit e;
      run = (rise_cnt[i] != c0[i]);
      e   = exp_run(sw_en[i], oe_n[i], pwr_good);
      chk(run == e, $sformatf("R1 out%0d running", i), int'(run), int'(e));
      if (!e) chk(clk_out[i] == 1'b0, $sformatf("R2 out%0d idle level", i),
                  int'(clk_out[i]), 0);
    end
    chk((fb_rise != f0) == pwr_good, "R7 feedback running", int'(fb_rise != f0), int'(pwr_good));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int ch_list [3];
    time t0;
    int lat;
    int c0;
    int f0;
    void'($urandom(32'd2024));
    ch_list[0] = 0; ch_list[1] = 5; ch_list[2] = 11;

    // Power down from the start
    #1 pwr_good = 1'b0;
    settle(2); #5;
    f0 = fb_rise;
    c0 = rise_cnt[0];
    settle(4); #5;
    chk(clk_out == '0, "R6 reset outputs low", int'(clk_out), 0);
    chk(fb_rise == f0 && clk_fb == 1'b0, "R6 feedback silent in powerdown", fb_rise - f0, 0);
    chk(rise_cnt[0] == c0, "R6 no pulses in powerdown", rise_cnt[0] - c0, 0);

    // Power up: feedback starts, gated outputs stay off (all pins high)
    drive_point();
    pwr_good = 1'b1;
    t0 = $time;
    lat = 1000;
    for (int k = 0; k < 200; k++) begin
      if (clk_fb) begin lat = int'($time - t0); break; end
      #1;
    end
    chk(lat <= 4 * PER, "R7 feedback start latency", lat, 4 * PER);
    settle(14);
    check_state();

    // Start latency on several outputs
    foreach (ch_list[j]) begin
      drive_point();
      oe_n[ch_list[j]] = 1'b0;
      t0 = $time;
      lat = 100000;
      for (int k = 0; k < 400; k++) begin
        if (clk_out[ch_list[j]]) begin lat = int'($time - t0); break; end
        #1;
      end
      chk(lat >= 4 * PER && lat <= 12 * PER,
          $sformatf("R4 out%0d start latency", ch_list[j]), lat, 5 * PER);
      settle(4);
    end
    settle(10);
    check_state();

    // Stop through the configuration bit (outputs 0 and 5), then through the pin (11)
    foreach (ch_list[j]) begin
      int ch;
      ch = ch_list[j];
      c0 = rise_cnt[ch];
      drive_point();
      if (j < 2) sw_en[ch] = 1'b0;
      else       oe_n[ch]  = 1'b1;
      t0 = $time;
      settle(15); #5;
      chk(rise_cnt[ch] - c0 >= 4, $sformatf("R5 out%0d trailing pulses", ch),
          rise_cnt[ch] - c0, 5);
      chk(last_fall[ch] > t0 && (last_fall[ch] - t0) <= 12 * PER,
          $sformatf("R5 out%0d stop time", ch), int'(last_fall[ch] - t0), 12 * PER);
      chk(clk_out[ch] == 1'b0, $sformatf("R2 out%0d stopped low", ch), int'(clk_out[ch]), 0);
    end

    // Truth table corners on output 3
    drive_point(); sw_en[3] = 1'b0; oe_n[3] = 1'b0;
    settle(14); check_state();
    drive_point(); sw_en[3] = 1'b1; oe_n[3] = 1'b1;
    settle(14); check_state();
    drive_point(); sw_en[3] = 1'b1; oe_n[3] = 1'b0;
    settle(14); check_state();

    // Request shorter than the start-up time: no pulse at all
    c0 = rise_cnt[7];
    drive_point(); oe_n[7] = 1'b0;
    #(PER);
    oe_n[7] = 1'b1;
    settle(15); #5;
    chk(rise_cnt[7] == c0, "R8 aborted start emits nothing", rise_cnt[7] - c0, 0);

    // Power loss while outputs run: immediate silence, then clean restart
    oe_n = 12'h0F0; sw_en = '1;
    settle(14);
    drive_point();
    pwr_good = 1'b0;
    #1;
    chk(clk_out == '0 && clk_fb == 1'b0, "R6 immediate silence", int'(clk_out), 0);
    settle(6);
    check_state();
    drive_point();
    pwr_good = 1'b1;
    settle(16);
    check_state();

    // Constrained random asynchronous activity
    for (int it = 0; it < 150; it++) begin
      int act;
      drive_point();
      act = int'($urandom_range(0, 19));
      if (act == 0)       pwr_good = ~pwr_good;
      else if (act < 10)  oe_n[$urandom_range(0, NOUT-1)] ^= 1'b1;
      else if (act < 16)  sw_en[$urandom_range(0, NOUT-1)] ^= 1'b1;
      else                oe_n = NOUT'($urandom());
      if (it % 6 == 5) begin
        if (!pwr_good && ($urandom_range(0, 1) == 1)) pwr_good = 1'b1;
        settle(16);
        check_state();
      end else begin
        #(int'($urandom_range(0, 5)) * PER);
      end
    end
    pwr_good = 1'b1;
    settle(16);
    check_state();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
      $finish;
    end
  end

endmodule